// File: doc/BRIEF.md
# Interrupt Source Gate Register Bank

This block is a bank of memory-mapped control registers that decide which interrupt sources may reach the pending aggregator. Each register is configured as one of three kinds. A mask pair has one address that sets bits and another that clears them, both acting on one stored word made of 1-bit fields. A priority pair works the same way but splits the word into fields of a configured width. A single-address priority register is overwritten directly. Every bit or field is tied to a source ID by a parameter map.

On each accepted write the block keeps the old word and the new word and then walks the fields one per cycle. Field 0 is the most significant field. For every field whose value changed it sends one event to the aggregator. The event carries the mapped source ID and says enable when the new field is nonzero and disable when it is zero. The bus is held off with a ready signal until the walk is over. Reads complete at once and return the stored word. Before matching, the address is cut down to its low 29 bits, so address windows that differ only in the top three bits reach the same register.

Top module: `irq_gate_regs`

## Requirements
- R1: Only address bits 28:0 take part in matching, so setting any of bits 31:29 reaches the same register as the plain address.
- R2: A write to the set address of a mask pair or priority pair stores the old word ORed with the write data.
- R3: A write to the clear address of a pair stores the old word ANDed with the inverse of the write data.
- R4: A write to the address of a single-address priority register stores the write data unchanged.
- R5: Mask registers have DATA_W fields of 1 bit each, and priority registers have DATA_W/PRIO_W fields of PRIO_W bits each. Field k sits at bit offset (fields-1-k)*width and maps to source SRC_MAP entry (reg*DATA_W+k). Events leave in increasing k, at most one per cycle.
- R6: A field produces an event only if its old and new values differ. evtEnable is 1 when the new field value is nonzero and 0 when it is zero.
- R7: A changed field whose mapped source ID is 0 produces no event, and evtSrc is never 0 while evtValid is high.
- R8: A read at either address of a pair returns the shared stored word in the same cycle, with busReady high.
- R9: For a mapped write, busReady rises exactly fields+1 cycles after the request is first seen. Events come only while the write is held and never in the cycle in which busReady is high.
- R10: A write to an unmapped address changes no register, sends no event and completes one cycle later. A read from an unmapped address returns 0.
- R11: After reset every stored word is 0 and no event is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Request present; held until busReady |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W | Request address |
| busWdata | input | DATA_W | Write data |
| busReady | output | 1 | Request completes in this cycle |
| busRdata | output | DATA_W | Read data, valid with busReady on a read |
| evtValid | output | 1 | Enable or disable event present |
| evtEnable | output | 1 | 1 enable, 0 disable |
| evtSrc | output | SRC_W | Source ID of the event |

## Verification
The bench builds the block with four registers of 16 bits and 4-bit priority fields. These are two mask pairs, one priority pair and one single-address priority register. This covers every access kind and both field widths in one run. It passes its own source map, in which every fifth map slot holds ID 0, so changed fields with no source are met often under random data. The set and clear addresses are also reached with random values in the top three address bits and mixed with unmapped addresses. This makes the aliasing, the ignore rules and the per-write hold time testable against a bench model.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;

  localparam int ALIAS_BITS = 29;

  typedef enum logic [1:0] {
    KIND_MASK_PAIR   = 2'd0,
    KIND_PRIO_PAIR   = 2'd1,
    KIND_PRIO_SINGLE = 2'd2
  } regKind_e;

  typedef enum logic [1:0] {
    ACC_NONE   = 2'd0,
    ACC_OR     = 2'd1,
    ACC_ANDNOT = 2'd2,
    ACC_DIRECT = 2'd3
  } accMode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_DONE = 2'd2
  } gateState_e;

  typedef struct packed {
    logic capture;
    logic scan;
    logic finish;
  } gateStrobe_t;

endpackage

// File: rtl/gate_addr_decode.sv
module gate_addr_decode
  import irq_gate_pkg::*;
#(
  parameter int NUM_REG = 2,
  parameter int ADDR_W = 32,
  parameter logic [NUM_REG*2-1:0] REG_KIND = '0,
  parameter logic [NUM_REG*ADDR_W-1:0] SET_ADDR = '0,
  parameter logic [NUM_REG*ADDR_W-1:0] CLR_ADDR = '0,
  localparam int REG_IDX_W = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic [ADDR_W-1:0]    busAddr,
  output logic                 hit,
  output logic [REG_IDX_W-1:0] hitIdx,
  output accMode_e             hitMode,
  output regKind_e             hitKind
);

  logic [NUM_REG-1:0] setHit;
  logic [NUM_REG-1:0] clrHit;
  regKind_e kindOf [NUM_REG];
  logic [ALIAS_BITS-1:0] addrLow;

  assign addrLow = busAddr[ALIAS_BITS-1:0];

  for (genvar r = 0; r < NUM_REG; r++) begin : g_match
    assign kindOf[r] = regKind_e'(REG_KIND[r*2 +: 2]);
    assign setHit[r] = (addrLow == SET_ADDR[r*ADDR_W +: ALIAS_BITS]);
    assign clrHit[r] = (kindOf[r] != KIND_PRIO_SINGLE) &&
                       (addrLow == CLR_ADDR[r*ADDR_W +: ALIAS_BITS]);
  end

  // lowest register index wins when two windows overlap
  always_comb begin
    hit     = 1'b0;
    hitIdx  = '0;
    hitMode = ACC_NONE;
    hitKind = KIND_MASK_PAIR;
    for (int r = NUM_REG - 1; r >= 0; r--) begin
      if (setHit[r] || clrHit[r]) begin
        hit     = 1'b1;
        hitIdx  = REG_IDX_W'(r);
        hitKind = kindOf[r];
        if (setHit[r]) hitMode = (kindOf[r] == KIND_PRIO_SINGLE) ? ACC_DIRECT : ACC_OR;
        else           hitMode = ACC_ANDNOT;
      end
    end
  end

endmodule

// File: rtl/gate_datapath.sv
module gate_datapath
  import irq_gate_pkg::*;
#(
  parameter int NUM_REG = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int PRIO_W = 4,
  parameter int SRC_W = 6,
  parameter logic [NUM_REG*2-1:0] REG_KIND = '0,
  parameter logic [NUM_REG*ADDR_W-1:0] SET_ADDR = '0,
  parameter logic [NUM_REG*ADDR_W-1:0] CLR_ADDR = '0,
  parameter logic [NUM_REG*DATA_W*SRC_W-1:0] SRC_MAP = '0,
  localparam int FIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1,
  localparam int REG_IDX_W = (NUM_REG > 1) ? $clog2(NUM_REG) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  input  gateStrobe_t       strobe,
  input  logic [FIDX_W-1:0] fieldIdx,
  output logic              addrHit,
  output logic              lastField,
  output logic [DATA_W-1:0] rdData,
  output logic              evtValid,
  output logic              evtEnable,
  output logic [SRC_W-1:0]  evtSrc
);

  localparam int NF_PRIO = DATA_W / PRIO_W;
  localparam logic [DATA_W-1:0] ONE_BIT = DATA_W'(1);
  localparam logic [DATA_W-1:0] PRIO_ONES = DATA_W'((1 << PRIO_W) - 1);

  logic [REG_IDX_W-1:0] hitIdx;
  accMode_e             hitMode;
  regKind_e             hitKind;

  logic [DATA_W-1:0] regVal [NUM_REG];
  logic [DATA_W-1:0] nextVal;
  logic [DATA_W-1:0] oldQ, newQ;
  logic [REG_IDX_W-1:0] curIdx;
  logic curIsMask;
  logic [DATA_W-1:0] fMask;
  int   shiftAmt;
  int   nfCur;

  gate_addr_decode #(
    .NUM_REG(NUM_REG), .ADDR_W(ADDR_W), .REG_KIND(REG_KIND),
    .SET_ADDR(SET_ADDR), .CLR_ADDR(CLR_ADDR)
  ) u_decode (
    .busAddr(busAddr), .hit(addrHit), .hitIdx(hitIdx),
    .hitMode(hitMode), .hitKind(hitKind)
  );

  always_comb begin
    case (hitMode)
      ACC_OR:     nextVal = regVal[hitIdx] | busWdata;
      ACC_ANDNOT: nextVal = regVal[hitIdx] & ~busWdata;
      ACC_DIRECT: nextVal = busWdata;
      default:    nextVal = regVal[hitIdx];
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_REG; r++) regVal[r] <= '0;
      oldQ      <= '0;
      newQ      <= '0;
      curIdx    <= '0;
      curIsMask <= 1'b1;
    end else if (strobe.capture) begin
      regVal[hitIdx] <= nextVal;
      oldQ           <= regVal[hitIdx];
      newQ           <= nextVal;
      curIdx         <= hitIdx;
      curIsMask      <= (hitKind == KIND_MASK_PAIR);
    end
  end

  // field k of the captured register, most significant field first
  always_comb begin
    nfCur    = curIsMask ? DATA_W : NF_PRIO;
    shiftAmt = curIsMask ? (DATA_W - 1 - int'(fieldIdx))
                         : (NF_PRIO - 1 - int'(fieldIdx)) * PRIO_W;
    fMask    = (curIsMask ? ONE_BIT : PRIO_ONES) << shiftAmt;
  end

  assign lastField = (int'(fieldIdx) == nfCur - 1);
  assign evtSrc    = SRC_MAP[(int'(curIdx) * DATA_W + int'(fieldIdx)) * SRC_W +: SRC_W];
  assign evtEnable = |(newQ & fMask);
  assign evtValid  = strobe.scan && (|((oldQ ^ newQ) & fMask)) && (evtSrc != '0);
  assign rdData    = addrHit ? regVal[hitIdx] : '0;

endmodule

// File: rtl/gate_ctrl.sv
module gate_ctrl
  import irq_gate_pkg::*;
#(
  parameter int FIDX_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              addrHit,
  input  logic              lastField,
  output gateStrobe_t       strobe,
  output logic [FIDX_W-1:0] fieldIdx,
  output logic              busReady
);

  gateState_e state, stateNext;
  logic idle;

  assign idle = (state == ST_IDLE);

  always_comb begin
    strobe.capture = idle && busValid && busWrite && addrHit;
    strobe.scan    = (state == ST_SCAN);
    strobe.finish  = (state == ST_DONE);
  end

  assign busReady = (idle && busValid && !busWrite) || strobe.finish;

  always_comb begin
    stateNext = state;
    case (state)
      ST_IDLE: if (busValid && busWrite) stateNext = addrHit ? ST_SCAN : ST_DONE;
      ST_SCAN: if (lastField) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      fieldIdx <= '0;
    end else begin
      state <= stateNext;
      if (strobe.capture) fieldIdx <= '0;
      else if (strobe.scan && !lastField) fieldIdx <= fieldIdx + 1'b1;
    end
  end

endmodule

// File: rtl/irq_gate_regs.sv
module irq_gate_regs
  import irq_gate_pkg::*;
#(
  parameter int NUM_REG = 2,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 16,
  parameter int PRIO_W = 4,
  parameter int SRC_W = 6,
  parameter logic [NUM_REG*2-1:0] REG_KIND = {2'd1, 2'd0},
  parameter logic [NUM_REG*ADDR_W-1:0] SET_ADDR = {32'h0000_0104, 32'h0000_0100},
  parameter logic [NUM_REG*ADDR_W-1:0] CLR_ADDR = {32'h0000_0114, 32'h0000_0110},
  parameter logic [NUM_REG*DATA_W*SRC_W-1:0] SRC_MAP = {(NUM_REG*DATA_W){SRC_W'(1)}}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic              busReady,
  output logic [DATA_W-1:0] busRdata,
  output logic              evtValid,
  output logic              evtEnable,
  output logic [SRC_W-1:0]  evtSrc
);

  localparam int FIDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  gateStrobe_t       strobe;
  logic [FIDX_W-1:0] fieldIdx;
  logic              addrHit;
  logic              lastField;

  gate_ctrl #(.FIDX_W(FIDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .addrHit(addrHit), .lastField(lastField), .strobe(strobe),
    .fieldIdx(fieldIdx), .busReady(busReady)
  );

  gate_datapath #(
    .NUM_REG(NUM_REG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W),
    .SRC_W(SRC_W), .REG_KIND(REG_KIND), .SET_ADDR(SET_ADDR),
    .CLR_ADDR(CLR_ADDR), .SRC_MAP(SRC_MAP)
  ) u_dp (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .strobe(strobe), .fieldIdx(fieldIdx), .addrHit(addrHit),
    .lastField(lastField), .rdData(busRdata), .evtValid(evtValid),
    .evtEnable(evtEnable), .evtSrc(evtSrc)
  );

endmodule

// File: rtl/irq_gate_regs_checker.sv
module irq_gate_regs_checker #(
  parameter int SRC_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             busValid,
  input logic             busWrite,
  input logic             busReady,
  input logic             evtValid,
  input logic [SRC_W-1:0] evtSrc
);

  AST_EVT_SRC_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (evtSrc != '0)); // R7

  AST_EVT_NOT_AT_READY: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> !busReady); // R9

  AST_EVT_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    evtValid |-> (busValid && busWrite)); // R9

  AST_QUIET_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (busReady && busValid && busWrite) |=> !evtValid); // R9

  AST_WRITE_READY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (busReady && busValid && busWrite) |=> !(busReady && busWrite)); // R9

endmodule

bind irq_gate_regs irq_gate_regs_checker #(.SRC_W(SRC_W)) u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busReady(busReady), .evtValid(evtValid), .evtSrc(evtSrc)
);

// File: tb/irq_gate_regs_bench.sv
module irq_gate_regs_bench;

  localparam int NUM_REG = 4;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 16;
  localparam int PRIO_W = 4;
  localparam int SRC_W = 6;
  // kinds: reg0 mask pair, reg1 priority pair, reg2 priority single, reg3 mask pair
  localparam logic [NUM_REG*2-1:0] KIND = {2'd0, 2'd2, 2'd1, 2'd0};
  localparam logic [NUM_REG*ADDR_W-1:0] SETA =
    {32'h0400_0080, 32'h0400_0008, 32'h0400_0004, 32'h0400_0040};
  localparam logic [NUM_REG*ADDR_W-1:0] CLRA =
    {32'h0400_00A0, 32'h0000_0000, 32'h0400_0024, 32'h0400_0060};

  function automatic int mapId(int r, int k);
    int n;
    n = r * DATA_W + k;
    return ((n % 5) == 3) ? 0 : ((n % 63) + 1);
  endfunction

  function automatic logic [NUM_REG*DATA_W*SRC_W-1:0] buildMap();
    logic [NUM_REG*DATA_W*SRC_W-1:0] m;
    m = '0;
    for (int r = 0; r < NUM_REG; r++)
      for (int k = 0; k < DATA_W; k++)
        m[(r*DATA_W+k)*SRC_W +: SRC_W] = SRC_W'(mapId(r, k));
    return m;
  endfunction

  localparam logic [NUM_REG*DATA_W*SRC_W-1:0] MAP = buildMap();

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 1'b0;
  logic busWrite = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [DATA_W-1:0] busWdata = '0;
  logic busReady;
  logic [DATA_W-1:0] busRdata;
  logic evtValid, evtEnable;
  logic [SRC_W-1:0] evtSrc;

  always #2 clk = ~clk;

  irq_gate_regs #(
    .NUM_REG(NUM_REG), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRIO_W(PRIO_W),
    .SRC_W(SRC_W), .REG_KIND(KIND), .SET_ADDR(SETA), .CLR_ADDR(CLRA), .SRC_MAP(MAP)
  ) u_irq_gate_regs (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busReady(busReady),
    .busRdata(busRdata), .evtValid(evtValid), .evtEnable(evtEnable), .evtSrc(evtSrc)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [DATA_W-1:0] model [NUM_REG];
  logic [SRC_W:0] gotEv [64];
  int gotN = 0;
  logic [SRC_W:0] expEv [64];
  int expN;

  always @(negedge clk)
    if (rstN && evtValid && gotN < 64) begin
      gotEv[gotN] = {evtEnable, evtSrc};
      gotN++;
    end

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // 0 none, 1 or, 2 andnot, 3 direct
  task automatic refDecode(input logic [ADDR_W-1:0] a, output int r, output int mode);
    r = -1; mode = 0;
    for (int i = NUM_REG - 1; i >= 0; i--) begin
      if (a[28:0] == SETA[i*ADDR_W +: 29]) begin
        r = i; mode = (KIND[i*2 +: 2] == 2'd2) ? 3 : 1;
      end else if (KIND[i*2 +: 2] != 2'd2 && a[28:0] == CLRA[i*ADDR_W +: 29]) begin
        r = i; mode = 2;
      end
    end
  endtask

  task automatic xfer(input bit wr, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d, output int lat,
                      output logic [DATA_W-1:0] rd);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busAddr = a; busWdata = d;
    gotN = 0;
    lat = 0;
    #1;
    while (!busReady) begin
      @(negedge clk); #1;
      lat++;
    end
    rd = busRdata;
    @(posedge clk); #1;
    busValid = 1'b0;
  endtask

  task automatic doWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    int r, mode, lat, nf, w, sh;
    logic [DATA_W-1:0] nv, ov, fm, rd;
    refDecode(a, r, mode);
    expN = 0;
    nf = 0;
    if (r >= 0) begin
      ov = model[r];
      nv = (mode == 1) ? (ov | d) : (mode == 2) ? (ov & ~d) : d;
      w  = (KIND[r*2 +: 2] == 2'd0) ? 1 : PRIO_W;
      nf = DATA_W / w;
      for (int k = 0; k < nf; k++) begin
        sh = (nf - 1 - k) * w;
        fm = DATA_W'((1 << w) - 1) << sh;
        if (((ov ^ nv) & fm) != 0 && mapId(r, k) != 0) begin
          expEv[expN] = {|(nv & fm), SRC_W'(mapId(r, k))};
          expN++;
        end
      end
      model[r] = nv;
    end
    xfer(1'b1, a, d, lat, rd);
    if (r >= 0) chk(lat == nf + 1, "R9 write hold cycles", lat, nf + 1);
    else        chk(lat == 1, "R10 unmapped write cycles", lat, 1);
    chk(gotN == expN, (r < 0) ? "R10 event count" : "R6 event count", gotN, expN);
    for (int i = 0; i < expN && i < gotN; i++)
      chk(gotEv[i] == expEv[i], "R5 event order/value", gotEv[i], expEv[i]);
  endtask

  task automatic doRead(input logic [ADDR_W-1:0] a, input string req);
    int r, mode, lat;
    logic [DATA_W-1:0] rd, ex;
    refDecode(a, r, mode);
    ex = (r >= 0) ? model[r] : '0;
    xfer(1'b0, a, '0, lat, rd);
    chk(rd == ex, req, rd, ex);
    chk(lat == 0, "R8 read wait", lat, 0);
    chk(gotN == 0, "R8 read no event", gotN, 0);
  endtask

  function automatic logic [ADDR_W-1:0] setAt(int r);
    return SETA[r*ADDR_W +: ADDR_W];
  endfunction
  function automatic logic [ADDR_W-1:0] clrAt(int r);
    return CLRA[r*ADDR_W +: ADDR_W];
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    int r;
    for (int i = 0; i < NUM_REG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    chk(evtValid == 1'b0, "R11 no event in reset", evtValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(evtValid == 1'b0 && busReady == 1'b0, "R11 idle outputs", {evtValid, busReady}, 0);
    for (int i = 0; i < NUM_REG; i++) doRead(setAt(i), "R11 reset value");

    doWrite(setAt(0), 16'hA5F0);                 // R2 mask set
    doRead(clrAt(0), "R8 read clear address");
    doWrite(clrAt(0), 16'h00F0);                 // R3 mask clear
    doRead(setAt(0), "R3 clear result");
    doWrite(setAt(0), 16'h0000);                 // R6 no change, no events
    doWrite(setAt(0), 16'h1000);                 // R7 field mapped to 0
    doRead(setAt(0), "R2 set result");
    doWrite(setAt(1), 16'hF0F0);                 // R5 priority fields
    doWrite(clrAt(1), 16'h3000);                 // R3 partial field change
    doRead(clrAt(1), "R8 priority pair read");
    doWrite(setAt(2), 16'h1234);                 // R4 direct write
    doWrite(setAt(2), 16'h1034);                 // R4 overwrite
    doRead(setAt(2), "R4 direct value");
    doWrite(setAt(3) | 32'hE000_0000, 16'hFFFF); // R1 alias
    doRead(clrAt(3) | 32'h4000_0000, "R1 aliased read");
    doWrite(32'h0400_0100, 16'hFFFF);            // R10 unmapped write
    doRead(32'h0400_0100, "R10 unmapped read");
    for (int i = 0; i < NUM_REG; i++) doRead(setAt(i), "R10 registers unchanged");

    void'($urandom(32'h5EED_1234));
    for (int n = 0; n < 300; n++) begin
      r = int'($urandom_range(0, NUM_REG - 1));
      a = ($urandom_range(0, 1) == 1 && KIND[r*2 +: 2] != 2'd2) ? clrAt(r) : setAt(r);
      if ($urandom_range(0, 9) == 0) a = 32'h0400_0100 + 32'($urandom_range(0, 15) * 4);
      a[31:29] = 3'($urandom_range(0, 7));
      d = 16'($urandom);
      if ($urandom_range(0, 3) == 0) d = d & 16'h0F0F;
      if ($urandom_range(0, 2) == 0) doRead(a, "R8 random read");
      else doWrite(a, d);
    end
    for (int i = 0; i < NUM_REG; i++) doRead(setAt(i), "R2 final value");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule